// File: doc/BRIEF.md
# Privileged-Access-Never Permission Checker

This block is the permission stage of a stage-1 address translation path. A translated request arrives with the access-permission bits, the two execute-never bits of the matching entry, the exception level of the requester, the kind of access, and two cache-operation qualifiers. The block decides, in the same cycle, whether the access is granted or raises a permission fault.

On top of the ordinary permission decode it adds a privileged-access-never pre-check. When the feature strap is set and the processor state bit that turns the feature on is 1, a privileged data access at EL1 or EL2 to a page that EL0 can also reach is refused. The block reports such refusals on a separate output, so that callers can tell them apart from ordinary permission faults. Instruction fetches are exempt, and so are cache-maintenance operations, except the zero-a-block operation, which is treated as a normal data write.

Top module: `pan_perm_check`

## Requirements
- R1: While reqValid is 0, grant, permFault and panDeny are all 0.
- R2: While reqValid is 1, exactly one of grant and permFault is 1, and panDeny=1 only together with permFault=1.
- R3: At EL1 (excLevel=1) or EL2 (excLevel=2), a read (accKind=0) or write (accKind=1) with panImplemented=1, pstatePan=1 and apBits[0]=1 (page reachable from EL0) gives panDeny=1 and permFault=1, whatever the ordinary decode would allow.
- R4: An execute access (accKind=2) never gives panDeny.
- R5: A request with isCacheMaint=1 and isBlockZero=0 never gives panDeny; with isCacheMaint=1 and isBlockZero=1 it is checked like any data access.
- R6: At EL0 (excLevel=0) and EL3 (excLevel=3) panDeny is always 0.
- R7: With panImplemented=0 or pstatePan=0, panDeny is always 0.
- R8: At EL1 the ordinary decode indexes on {apBits, xnBit, pxnBit}: reads are granted; writes are granted when apBits[1]=0 (apBits[1]=1 marks read-only); execution is granted when pxnBit=0 and apBits is not 2'b01.
- R9: At EL0 a read is granted when apBits[0]=1, a write when apBits=2'b01, and execution when xnBit=0.
- R10: At EL2 and EL3 the ordinary decode indexes on {apBits[1], xnBit}: reads are granted, writes are granted when apBits[1]=0, execution is granted when xnBit=0.
- R11: The reserved access code accKind=3 always gives permFault=1, grant=0 and panDeny=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqValid | input | 1 | A request is present this cycle |
| excLevel | input | 2 | Exception level of the requester, 0 to 3 |
| accKind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| apBits | input | 2 | Entry permissions: bit 1 read-only, bit 0 reachable from EL0 |
| xnBit | input | 1 | Entry execute-never bit |
| pxnBit | input | 1 | Entry privileged execute-never bit |
| isCacheMaint | input | 1 | The request is a cache-maintenance operation |
| isBlockZero | input | 1 | The cache operation is the zero-a-block operation |
| pstatePan | input | 1 | Processor state bit enabling the pre-check |
| panImplemented | input | 1 | Feature strap: the pre-check exists |
| grant | output | 1 | Access allowed |
| permFault | output | 1 | Access refused with a permission fault |
| panDeny | output | 1 | The refusal came from the privileged-access-never pre-check |

## Verification
The assertions watch, every cycle, that grant and permFault never rise together, that a pre-check refusal always comes with a fault, that a fetch or the reserved access code is never refused by the pre-check, that the pre-check stays inside EL1 and EL2 and needs both strap and state bit, and that an idle cycle drives nothing. Which table entry grants which access, and the exact exemption of cache operations, can only be shown by the bench, which walks every combination of the inputs against its own behavioural model and compares all three outputs each clock.

// File: rtl/pan_perm_pkg.sv
package pan_perm_pkg;

  localparam int LVL_W = 2;
  localparam int ACC_W = 2;
  localparam int AP_W  = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_USER  = 2'd0,
    LVL_KERN  = 2'd1,
    LVL_HYP   = 2'd2,
    LVL_MON   = 2'd3
  } lvl_e;

  typedef enum logic [ACC_W-1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EXEC = 2'd2,
    ACC_RSV  = 2'd3
  } acc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic panHit;
    logic selUser;
    logic selKern;
    logic selHigh;
    logic accRead;
    logic accWrite;
    logic accExec;
    logic accBad;
  } strobe_t;

endpackage

// File: rtl/pan_perm_ctrl.sv
module pan_perm_ctrl
  import pan_perm_pkg::*;
#(
  parameter logic [3:0] PAN_LVL_MASK = 4'b0110
) (
  input  logic             reqValid,
  input  logic [LVL_W-1:0] excLevel,
  input  logic [ACC_W-1:0] accKind,
  input  logic             apUserBit,
  input  logic             isCacheMaint,
  input  logic             isBlockZero,
  input  logic             pstatePan,
  input  logic             panImplemented,
  output strobe_t          stb
);

  logic dataAcc;
  logic cmoExempt;
  logic lvlInScope;

  always_comb begin
    stb          = '0;
    stb.accRead  = reqValid && (accKind == ACC_RD);
    stb.accWrite = reqValid && (accKind == ACC_WR);
    stb.accExec  = reqValid && (accKind == ACC_EXEC);
    stb.accBad   = reqValid && (accKind == ACC_RSV);
    stb.selUser  = reqValid && (excLevel == LVL_USER);
    stb.selKern  = reqValid && (excLevel == LVL_KERN);
    stb.selHigh  = reqValid && ((excLevel == LVL_HYP) || (excLevel == LVL_MON));

    dataAcc    = stb.accRead || stb.accWrite;
    cmoExempt  = isCacheMaint && !isBlockZero;
    lvlInScope = PAN_LVL_MASK[excLevel];

    stb.panHit = panImplemented && pstatePan && apUserBit &&
                 dataAcc && !cmoExempt && lvlInScope;
  end

  // Guards on the pre-check strobe
  always_comb begin
    a_r6_pan_level_scope: assert (!stb.panHit ||
      ((excLevel != LVL_USER) && (excLevel != LVL_MON)));
    a_r7_pan_needs_enable: assert (!stb.panHit || (panImplemented && pstatePan));
    a_r5_cmo_exempt: assert (!(stb.panHit && isCacheMaint && !isBlockZero));
  end

endmodule

// File: rtl/pan_perm_dp.sv
module pan_perm_dp
  import pan_perm_pkg::*;
(
  input  strobe_t         stb,
  input  logic [AP_W-1:0] apBits,
  input  logic            xnBit,
  input  logic            pxnBit,
  output logic            grant,
  output logic            permFault,
  output logic            panDeny
);

  localparam int KERN_IDX_W = AP_W + 2;
  localparam int KERN_N     = 1 << KERN_IDX_W;
  localparam int HIGH_IDX_W = 2;
  localparam int HIGH_N     = 1 << HIGH_IDX_W;

  logic [KERN_N-1:0] kernRd, kernWr, kernEx;
  logic [HIGH_N-1:0] highRd, highWr, highEx;

  // Kernel-level table, indexed by {ap, xn, pxn}
  for (genvar i = 0; i < KERN_N; i++) begin : g_kern
    localparam logic [KERN_IDX_W-1:0] IDX = KERN_IDX_W'(i);
    assign kernRd[i] = 1'b1;
    assign kernWr[i] = ~IDX[KERN_IDX_W-1];
    assign kernEx[i] = ~IDX[0] & (IDX[KERN_IDX_W-1 -: AP_W] != 2'b01);
  end

  // Hypervisor/monitor table, indexed by {ap[1], xn}
  for (genvar j = 0; j < HIGH_N; j++) begin : g_high
    localparam logic [HIGH_IDX_W-1:0] IDX = HIGH_IDX_W'(j);
    assign highRd[j] = 1'b1;
    assign highWr[j] = ~IDX[1];
    assign highEx[j] = ~IDX[0];
  end

  logic [KERN_IDX_W-1:0] kernIdx;
  logic [HIGH_IDX_W-1:0] highIdx;
  logic kernOk, highOk, userOk, ordOk, anyReq;

  always_comb begin
    kernIdx = {apBits, xnBit, pxnBit};
    highIdx = {apBits[1], xnBit};
    kernOk  = (stb.accRead  && kernRd[kernIdx]) ||
              (stb.accWrite && kernWr[kernIdx]) ||
              (stb.accExec  && kernEx[kernIdx]);
    highOk  = (stb.accRead  && highRd[highIdx]) ||
              (stb.accWrite && highWr[highIdx]) ||
              (stb.accExec  && highEx[highIdx]);
    userOk  = (stb.accRead  && apBits[0]) ||
              (stb.accWrite && (apBits == 2'b01)) ||
              (stb.accExec  && !xnBit);
    ordOk   = (stb.selKern && kernOk) ||
              (stb.selHigh && highOk) ||
              (stb.selUser && userOk);
    anyReq  = stb.accRead || stb.accWrite || stb.accExec || stb.accBad;

    grant     = ordOk && !stb.panHit;
    permFault = anyReq && !grant;
    panDeny   = stb.panHit;
  end

  always_comb begin
    a_r2_one_outcome: assert (!(grant && permFault));
    a_r2_pan_is_fault: assert (!panDeny || permFault);
    a_r4_fetch_exempt: assert (!(stb.accExec && panDeny));
    a_r11_reserved_denied: assert (!(stb.accBad && (grant || panDeny)));
  end

endmodule

// File: rtl/pan_perm_check.sv
module pan_perm_check
  import pan_perm_pkg::*;
#(
  parameter logic [3:0] PAN_LVL_MASK = 4'b0110
) (
  input  logic             reqValid,
  input  logic [LVL_W-1:0] excLevel,
  input  logic [ACC_W-1:0] accKind,
  input  logic [AP_W-1:0]  apBits,
  input  logic             xnBit,
  input  logic             pxnBit,
  input  logic             isCacheMaint,
  input  logic             isBlockZero,
  input  logic             pstatePan,
  input  logic             panImplemented,
  output logic             grant,
  output logic             permFault,
  output logic             panDeny
);

  strobe_t stb;

  pan_perm_ctrl #(.PAN_LVL_MASK(PAN_LVL_MASK)) u_ctrl (
    .reqValid       (reqValid),
    .excLevel       (excLevel),
    .accKind        (accKind),
    .apUserBit      (apBits[0]),
    .isCacheMaint   (isCacheMaint),
    .isBlockZero    (isBlockZero),
    .pstatePan      (pstatePan),
    .panImplemented (panImplemented),
    .stb            (stb)
  );

  pan_perm_dp u_dp (
    .stb       (stb),
    .apBits    (apBits),
    .xnBit     (xnBit),
    .pxnBit    (pxnBit),
    .grant     (grant),
    .permFault (permFault),
    .panDeny   (panDeny)
  );

  always_comb begin
    a_r1_idle_quiet: assert (reqValid || !(grant || permFault || panDeny));
    a_r2_valid_answers: assert (!reqValid || (grant != permFault));
  end

endmodule

// File: tb/sim_pan_perm_check.sv
module sim_pan_perm_check;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] excLevel = 2'd0;
  logic [1:0] accKind = 2'd0;
  logic [1:0] apBits = 2'd0;
  logic xnBit = 1'b0, pxnBit = 1'b0;
  logic isCacheMaint = 1'b0, isBlockZero = 1'b0;
  logic pstatePan = 1'b0, panImplemented = 1'b0;
  logic grant, permFault, panDeny;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  pan_perm_check u0 (
    .reqValid(reqValid), .excLevel(excLevel), .accKind(accKind),
    .apBits(apBits), .xnBit(xnBit), .pxnBit(pxnBit),
    .isCacheMaint(isCacheMaint), .isBlockZero(isBlockZero),
    .pstatePan(pstatePan), .panImplemented(panImplemented),
    .grant(grant), .permFault(permFault), .panDeny(panDeny)
  );

  // Behavioural reference: returns {grant, fault, pan}
  function automatic logic [2:0] refModel();
    bit pan, ok;
    if (!reqValid) return 3'b000;
    if (accKind == 3) return 3'b010;
    pan = panImplemented && pstatePan && apBits[0] && accKind != 2 &&
          (!isCacheMaint || isBlockZero) && (excLevel == 1 || excLevel == 2);
    if (pan) return 3'b011;
    case (excLevel)
      0: ok = (accKind == 0) ? apBits[0] : (accKind == 1) ? (apBits == 2'b01) : !xnBit;
      1: ok = (accKind == 0) ? 1'b1 : (accKind == 1) ? !apBits[1]
                             : (!pxnBit && apBits != 2'b01);
      default: ok = (accKind == 0) ? 1'b1 : (accKind == 1) ? !apBits[1] : !xnBit;
    endcase
    return ok ? 3'b100 : 3'b010;
  endfunction

  function automatic string tagFor();
    if (!reqValid) return "R1";
    if (accKind == 3) return "R11";
    if (refModel() == 3'b011) return "R3";
    if (accKind == 2 && pstatePan && panImplemented && apBits[0]) return "R4";
    if (isCacheMaint && !isBlockZero && pstatePan && panImplemented) return "R5";
    if (!(panImplemented && pstatePan)) return "R7";
    if (excLevel == 0) return "R9";
    if (excLevel == 1) return "R8";
    return "R10";
  endfunction

  task automatic compare(input string tag);
    logic [2:0] exp;
    exp = refModel();
    checks++;
    if ({grant, permFault, panDeny} !== exp) begin
      fails++;
      $display("FAIL %s: lvl=%0d acc=%0d ap=%b xn=%b pxn=%b cmo=%b bz=%b pan=%b have=%b got g/f/p=%b expected %b",
               tag, excLevel, accKind, apBits, xnBit, pxnBit, isCacheMaint,
               isBlockZero, pstatePan, panImplemented, {grant, permFault, panDeny}, exp);
    end
  endtask

  task automatic drive(input logic v, input int lvl, input int acc, input int ap,
                       input logic xn, input logic pxn, input logic cmo,
                       input logic bz, input logic ps, input logic hv);
    @(posedge clk);
    reqValid = v; excLevel = 2'(lvl); accKind = 2'(acc); apBits = 2'(ap);
    xnBit = xn; pxnBit = pxn; isCacheMaint = cmo; isBlockZero = bz;
    pstatePan = ps; panImplemented = hv;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");                               // idle state after reset

    // Directed corner cases
    drive(1, 1, 0, 1, 0, 0, 0, 0, 1, 1); compare("R3");   // kernel read of user page
    drive(1, 2, 1, 1, 0, 0, 0, 0, 1, 1); compare("R3");   // hyp write of user page
    drive(1, 1, 2, 1, 0, 0, 0, 0, 1, 1); compare("R4");   // fetch exempt
    drive(1, 1, 0, 1, 0, 0, 1, 0, 1, 1); compare("R5");   // maintenance exempt
    drive(1, 1, 1, 1, 0, 0, 1, 1, 1, 1); compare("R5");   // zero-block checked
    drive(1, 3, 0, 1, 0, 0, 0, 0, 1, 1); compare("R6");   // monitor level
    drive(1, 0, 0, 1, 0, 0, 0, 0, 1, 1); compare("R6");   // user level
    drive(1, 1, 0, 1, 0, 0, 0, 0, 1, 0); compare("R7");   // strap off
    drive(1, 1, 2, 0, 0, 1, 0, 0, 0, 0); compare("R8");   // pxn blocks kernel fetch
    drive(1, 1, 2, 1, 0, 0, 0, 0, 0, 0); compare("R8");   // user-writable not kernel-exec
    drive(1, 0, 1, 3, 0, 0, 0, 0, 0, 0); compare("R9");   // user write read-only
    drive(1, 2, 2, 0, 1, 0, 0, 0, 0, 0); compare("R10");  // xn blocks hyp fetch
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0, 0); compare("R11");  // reserved code
    drive(0, 1, 0, 1, 0, 0, 0, 0, 1, 1); compare("R1");   // idle with active inputs
    drive(1, 2, 0, 2, 0, 0, 0, 0, 1, 1); compare("R2");   // read-only kernel page, no user bit

    // Exhaustive sweep, compared every clock
    for (int v = 0; v < 2; v++)
      for (int l = 0; l < 4; l++)
        for (int a = 0; a < 4; a++)
          for (int p = 0; p < 4; p++)
            for (int m = 0; m < 64; m++) begin
              drive(1'(v), l, a, p, m[0], m[1], m[2], m[3], m[4], m[5]);
              compare(tagFor());
            end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule